// File: doc/BRIEF.md
# Bit-Field Extract, Insert and Lane Permute Unit

This unit performs the bit-field and byte-lane operations of a processor's integer pipe on one 64-bit datapath. From one opcode it extracts a field of a given position and size from a source word, inserts the low bits of a source word into a field of a destination word, swaps the bytes of every halfword, swaps the halfwords of every word, or sign-extends a byte or a halfword. A narrow-mode input limits each operation to the low 32 bits and clears the upper half of the result. The instruction decoder guarantees legal position and size pairs, so the unit does not check them.

The operands are captured with an input valid strobe. The result and a valid flag appear one clock later. Control is a two-state machine. It moves from ST_IDLE to ST_HOLD on the transition "accept" (valid input) and stays in ST_HOLD on "chain" (another valid input). It returns from ST_HOLD to ST_IDLE on "drain" (no valid input) and stays in ST_IDLE on "rest". In ST_HOLD the output is valid. The result register keeps its last value while no input is accepted.

Top module: `bitfield_unit`

## Requirements
- R1: After reset, out_valid is 0 and result is all zeros.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid high. When in_valid is low, result keeps its previous value.
- R3: Opcode 0 (extract) returns the source shifted right by pos, keeping only its low size bits. All bits above the field are zero.
- R4: Opcode 1 (insert) returns the destination with bits pos to pos+size-1 replaced by the low size bits of the source. All other bits keep their destination value.
- R5: A size equal to the full width (64 wide, 32 narrow) with pos 0 gives an all-ones field. Extract then returns the whole source and insert returns the whole source.
- R6: Opcode 2 exchanges the two bytes inside every 16-bit halfword.
- R7: Opcode 3 exchanges the two 16-bit halves inside every 32-bit word.
- R8: Opcode 4 returns source bits 7:0 with bit 7 copied into every higher bit.
- R9: Opcode 5 returns source bits 15:0 with bit 15 copied into every higher bit.
- R10: With narrow high, source bits 63:32 have no effect, pos uses bits 4:0 only, and result bits 63:32 are zero for every opcode.
- R11: Opcodes 6 and 7 are reserved and produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 3 | Operation code (0 extract, 1 insert, 2 byte swap in halfwords, 3 halfword swap in words, 4 byte sign-extend, 5 halfword sign-extend) |
| narrow | input | 1 | 32-bit mode when high |
| src | input | 64 | Source operand |
| dst | input | 64 | Destination operand, used only by insert |
| pos | input | 6 | Field start bit |
| size | input | 7 | Field length in bits, 1 to the width |
| out_valid | output | 1 | result is valid this cycle |
| result | output | 64 | Registered result |

## Verification
The main corner case is full-width size. A mask built by shifting a one left by size wraps to zero there, so a full extract would return zero and a full insert would leave the destination unchanged. Fields that end at bit 31 or bit 63 are covered, because an off-by-one mask boundary drops or adds the top bit. Narrow mode is run with garbage in the upper source half, so a design that forgets to clear or ignore that half leaks it into the result. The sign extensions are tested with the sign bit set and cleared, and the reserved opcodes are tested as well. Random legal position and size pairs are compared against an independent per-bit model.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    typedef enum logic [2:0] {
        OP_EXTRACT     = 3'd0,
        OP_INSERT      = 3'd1,
        OP_BSWAP_HALF  = 3'd2,
        OP_SWAP_HALVES = 3'd3,
        OP_SEXT_BYTE   = 3'd4,
        OP_SEXT_HALF   = 3'd5
    } bfu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } bfu_state_e;

endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
    parameter int XLEN = 64,
    parameter int PW   = $clog2(XLEN),
    parameter int SW   = PW + 1
) (
    input  logic            narrow,
    input  logic [PW-1:0]   pos,
    input  logic [SW-1:0]   size,
    output logic [PW-1:0]   eff_pos,
    output logic [XLEN-1:0] low_mask,
    output logic [XLEN-1:0] field_mask
);
    localparam int NW = XLEN / 2;
    localparam logic [PW-1:0] NARROW_POS_MASK = PW'(NW - 1);

    // Per-bit comparison: a full-width size sets every bit, no shift overflow.
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        localparam logic [SW-1:0] IDX    = SW'(i);
        localparam bit            IN_LOW = (i < NW);
        assign low_mask[i] = (IDX < size) && (IN_LOW || !narrow);
    end

    assign eff_pos    = narrow ? (pos & NARROW_POS_MASK) : pos;
    assign field_mask = low_mask << eff_pos;

endmodule

// File: rtl/bfu_field_ops.sv
module bfu_field_ops #(
    parameter int XLEN = 64,
    parameter int PW   = $clog2(XLEN)
) (
    input  logic            narrow,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] dst,
    input  logic [PW-1:0]   eff_pos,
    input  logic [XLEN-1:0] low_mask,
    input  logic [XLEN-1:0] field_mask,
    output logic [XLEN-1:0] ext_res,
    output logic [XLEN-1:0] ins_res
);
    localparam int NW = XLEN / 2;

    logic [XLEN-1:0] src_w;

    assign src_w   = narrow ? {{NW{1'b0}}, src[NW-1:0]} : src;
    assign ext_res = (src_w >> eff_pos) & low_mask;
    assign ins_res = (dst & ~field_mask) | ((src_w << eff_pos) & field_mask);

endmodule

// File: rtl/bfu_lane_ops.sv
module bfu_lane_ops #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] src,
    output logic [XLEN-1:0] bswap_res,
    output logic [XLEN-1:0] hswap_res,
    output logic [XLEN-1:0] sxb_res,
    output logic [XLEN-1:0] sxh_res
);
    localparam int NHALF = XLEN / 16;
    localparam int NWORD = XLEN / 32;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign bswap_res[16*h +: 16] = {src[16*h +: 8], src[16*h+8 +: 8]};
    end

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        assign hswap_res[32*w +: 32] = {src[32*w +: 16], src[32*w+16 +: 16]};
    end

    assign sxb_res = {{(XLEN-8){src[7]}},   src[7:0]};
    assign sxh_res = {{(XLEN-16){src[15]}}, src[15:0]};

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
    parameter int XLEN = 64,
    parameter int PW   = $clog2(XLEN),
    parameter int SW   = PW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      op,
    input  logic            narrow,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] dst,
    input  logic [PW-1:0]   pos,
    input  logic [SW-1:0]   size,
    output logic            out_valid,
    output logic [XLEN-1:0] result
);
    import bfu_pkg::*;

    localparam int NW = XLEN / 2;

    bfu_state_e      state_q, state_d;
    logic [XLEN-1:0] result_q;
    logic [XLEN-1:0] raw_res, next_res;

    logic [PW-1:0]   eff_pos;
    logic [XLEN-1:0] low_mask, field_mask;
    logic [XLEN-1:0] ext_res, ins_res;
    logic [XLEN-1:0] bswap_res, hswap_res, sxb_res, sxh_res;

    bfu_mask_gen #(.XLEN(XLEN), .PW(PW), .SW(SW)) u_mask (
        .narrow     (narrow),
        .pos        (pos),
        .size       (size),
        .eff_pos    (eff_pos),
        .low_mask   (low_mask),
        .field_mask (field_mask)
    );

    bfu_field_ops #(.XLEN(XLEN), .PW(PW)) u_field (
        .narrow     (narrow),
        .src        (src),
        .dst        (dst),
        .eff_pos    (eff_pos),
        .low_mask   (low_mask),
        .field_mask (field_mask),
        .ext_res    (ext_res),
        .ins_res    (ins_res)
    );

    bfu_lane_ops #(.XLEN(XLEN)) u_lane (
        .src        (src),
        .bswap_res  (bswap_res),
        .hswap_res  (hswap_res),
        .sxb_res    (sxb_res),
        .sxh_res    (sxh_res)
    );

    // Operation select; reserved codes give zero.
    always_comb begin
        unique case (op)
            OP_EXTRACT:     raw_res = ext_res;
            OP_INSERT:      raw_res = ins_res;
            OP_BSWAP_HALF:  raw_res = bswap_res;
            OP_SWAP_HALVES: raw_res = hswap_res;
            OP_SEXT_BYTE:   raw_res = sxb_res;
            OP_SEXT_HALF:   raw_res = sxh_res;
            default:        raw_res = '0;
        endcase
        next_res = narrow ? {{NW{1'b0}}, raw_res[NW-1:0]} : raw_res;
    end

    // Next-state logic: accept / chain enter ST_HOLD, drain / rest go to ST_IDLE.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result_q <= '0;
        else if (in_valid) result_q <= next_res;
    end

    assign out_valid = (state_q == ST_HOLD);
    assign result    = result_q;

endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
    parameter int XLEN = 64,
    parameter int PW   = $clog2(XLEN),
    parameter int SW   = PW + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      op,
    input logic            narrow,
    input logic [XLEN-1:0] src,
    input logic [PW-1:0]   pos,
    input logic [SW-1:0]   size,
    input logic            out_valid,
    input logic [XLEN-1:0] result
);
    localparam int NW = XLEN / 2;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R2
    AST_FULL_EXTRACT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0 && !narrow && size == SW'(XLEN) && pos == '0)
        |=> result == $past(src)); // R5
    AST_SEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4 && !narrow)
        |=> result[XLEN-1:8] == {(XLEN-8){$past(src[7])}}); // R8
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && narrow) |=> result[XLEN-1:NW] == '0); // R10
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2:1] == 2'b11) |=> result == '0); // R11

endmodule

bind bitfield_unit bfu_checker #(.XLEN(XLEN), .PW(PW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .narrow    (narrow),
    .src       (src),
    .pos       (pos),
    .size      (size),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic        narrow = 1'b0;
    logic [63:0] src = '0;
    logic [63:0] dst = '0;
    logic [5:0]  pos = '0;
    logic [6:0]  size = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bitfield_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .narrow(narrow),
        .src(src), .dst(dst), .pos(pos), .size(size),
        .out_valid(out_valid), .result(result)
    );

    // {op[3], narrow[1], pos[6], size[7], src[64], dst[64], expected[64]}
    localparam int NVEC = 14;
    localparam logic [208:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 6'd4,  7'd8,  64'h0000_0000_0000_0AB0, 64'h0, 64'h0000_0000_0000_00AB},
        {3'd1, 1'b0, 6'd8,  7'd8,  64'h0000_0000_0000_00CD, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_CDFF},
        {3'd2, 1'b0, 6'd0,  7'd1,  64'h0123_4567_89AB_CDEF, 64'h0, 64'h2301_6745_AB89_EFCD},
        {3'd3, 1'b0, 6'd0,  7'd1,  64'h0123_4567_89AB_CDEF, 64'h0, 64'h4567_0123_CDEF_89AB},
        {3'd4, 1'b0, 6'd0,  7'd1,  64'h0000_0000_0000_0080, 64'h0, 64'hFFFF_FFFF_FFFF_FF80},
        {3'd5, 1'b0, 6'd0,  7'd1,  64'h1234_5678_9ABC_7FFF, 64'h0, 64'h0000_0000_0000_7FFF},
        {3'd0, 1'b1, 6'd0,  7'd32, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 64'h0000_0000_CAFE_F00D},
        {3'd1, 1'b1, 6'd28, 7'd4,  64'hFFFF_FFFF_0000_000A, 64'h1111_1111_2222_2222, 64'h0000_0000_A222_2222},
        {3'd2, 1'b1, 6'd0,  7'd1,  64'h0123_4567_89AB_CDEF, 64'h0, 64'h0000_0000_AB89_EFCD},
        {3'd6, 1'b0, 6'd3,  7'd5,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
        {3'd0, 1'b0, 6'd0,  7'd64, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 64'hDEAD_BEEF_CAFE_F00D},
        {3'd4, 1'b1, 6'd0,  7'd1,  64'h0000_0000_0000_0080, 64'h0, 64'h0000_0000_FFFF_FF80},
        {3'd5, 1'b0, 6'd0,  7'd1,  64'h0000_0000_0000_8000, 64'h0, 64'hFFFF_FFFF_FFFF_8000},
        {3'd1, 1'b0, 6'd0,  7'd64, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF}
    };

    function automatic string tag_of(input logic [2:0] o, input logic n, input logic [6:0] s);
        if (o >= 3'd6) return "R11";
        if (n)         return "R10";
        if (s == 7'd64 && o <= 3'd1) return "R5";
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Independent per-bit reference model built from the requirements.
    function automatic logic [63:0] model(input logic [2:0] o, input logic n,
                                          input logic [5:0] p, input logic [6:0] s,
                                          input logic [63:0] a, input logic [63:0] d);
        logic [63:0] r;
        logic [63:0] av;
        int w;
        int pp;
        w  = n ? 32 : 64;
        pp = n ? int'(p[4:0]) : int'(p);
        av = n ? {32'h0, a[31:0]} : a;
        r  = '0;
        for (int i = 0; i < 64; i++) begin
            case (o)
                3'd0: r[i] = (i < int'(s) && i + pp < w) ? av[i + pp] : 1'b0;
                3'd1: r[i] = (i >= pp && i < pp + int'(s) && i < w) ? av[i - pp] : d[i];
                3'd2: r[i] = av[i ^ 8];
                3'd3: r[i] = av[i ^ 16];
                3'd4: r[i] = (i < 8)  ? av[i] : av[7];
                3'd5: r[i] = (i < 16) ? av[i] : av[15];
                default: r[i] = 1'b0;
            endcase
        end
        if (n) r[63:32] = '0;
        return r;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Drive at a falling edge, capture at the rising edge, check at the next falling edge.
    task automatic apply(input logic [2:0] o, input logic n, input logic [5:0] p,
                         input logic [6:0] s, input logic [63:0] a, input logic [63:0] d,
                         input logic [63:0] exp, input string tag);
        op = o; narrow = n; pos = p; size = s; src = a; dst = d;
        in_valid = 1'b1;
        @(negedge clk);
        check(tag, "out_valid", {63'h0, out_valid}, 64'h1);
        check(tag, "result", result, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        finish_run();
    end

    initial begin
        logic [63:0] last;
        repeat (2) @(negedge clk);
        check("R1", "reset out_valid", {63'h0, out_valid}, 64'h0);
        check("R1", "reset result", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            apply(VEC[k][208:206], VEC[k][205], VEC[k][204:199], VEC[k][198:192],
                  VEC[k][191:128], VEC[k][127:64], VEC[k][63:0],
                  tag_of(VEC[k][208:206], VEC[k][205], VEC[k][198:192]));
        end

        // R2: with no input the flag drops and the result holds, even as operands change.
        last = result;
        in_valid = 1'b0;
        src = 64'h5555_5555_5555_5555;
        op = 3'd2;
        @(negedge clk);
        check("R2", "idle out_valid", {63'h0, out_valid}, 64'h0);
        check("R2", "idle result hold", result, last);
        @(negedge clk);
        check("R2", "idle result hold 2", result, last);

        // R10: narrow source upper half ignored for a swap of halves.
        apply(3'd3, 1'b1, 6'd0, 7'd1, 64'hFFFF_FFFF_1234_5678, 64'h0,
              64'h0000_0000_5678_1234, "R10");

        // R3 / R4: random legal position and size pairs, wide and narrow.
        for (int k = 0; k < 400; k++) begin
            logic n;
            logic [2:0] o;
            int w;
            int s;
            int p;
            logic [63:0] a;
            logic [63:0] d;
            n = k[0];
            o = 3'(($urandom % 6));
            w = n ? 32 : 64;
            s = 1 + int'($urandom % w);
            p = int'($urandom % (w - s + 1));
            a = {$urandom, $urandom};
            d = {$urandom, $urandom};
            apply(o, n, 6'(p), 7'(s), a, d, model(o, n, 6'(p), 7'(s), a, d),
                  (o == 3'd1) ? "R4" : (o == 3'd0) ? "R3" : tag_of(o, n, 7'(s)));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", "final drain", {63'h0, out_valid}, 64'h0);
        finish_run();
    end

endmodule